// File: doc/BRIEF.md
# ULPI Link-Side Test Controller

This block stands in for the link end of a ULPI bus so that a stand-alone PHY can be exercised on its own. It runs in the PHY's 60 MHz clock domain. A host-side command port starts one operation at a time: a register write, a register read, a packet transmit from a small loadable byte buffer, or an error injection. A pulse on `done` or `aborted` reports how the operation ended. For a read, the returned byte appears on `rd_data`.

Two kinds of deliberately illegal bus behaviour are built in for validation. Error injection holds the all-ones byte on the data lines for a programmable number of cycles, whatever the PHY signals on nxt, and this makes the PHY send a transmit error on the USB lines. Float mode releases the data and stp output enables together, so that a PHY safeguard test can run with those lines undriven. On the bus side the block honours bus ownership and the one-cycle turnaround that follows every change of dir.

Top module: `ulpi_link_tester`

## Requirements
- R1: After reset the block is idle. `cmd_ready` is 1, `ulpi_data_oe` and `ulpi_stp_oe` are 1, `ulpi_data_o` is 0x00, and `ulpi_stp`, `done` and `aborted` are 0.
- R2: `ulpi_data_oe` is 0 in every cycle where `ulpi_dir` is 1. It is also 0 in the single turnaround cycle after any change of `ulpi_dir`, and the block ignores nxt and the data lines in that cycle.
- R3: A transmit command (`cmd_op`=3) first drives the byte {2'b01, 2'b00, `cmd_pid`}. It then drives buffer entries 0 to `cmd_len`-1 in order. Each byte stays on the bus until a cycle with `ulpi_nxt`=1, and the block moves to the next byte only in such a cycle.
- R4: One cycle after the final byte is accepted, `ulpi_stp` is 1 for exactly one cycle with data 0x00. `done` is 1 in the following cycle.
- R5: A register write (`cmd_op`=1) drives {2'b10, `cmd_addr`} until nxt, then `cmd_wdata` until nxt, and then ends with the stp cycle of R4.
- R6: A register read (`cmd_op`=2) drives {2'b11, `cmd_addr`} until nxt. When dir rises, the block waits through the turnaround cycle and captures the data lines in the cycle after it. In the next cycle `done` is 1 and `rd_data` holds the byte. With the PHY in full-speed mode, reading the function-control register at address 0x04 returns 0x45.
- R7: If dir rises while the block is driving a command byte, a data byte or the injected error bytes, the operation stops. `aborted` is 1 for one cycle, no stp is sent, `done` stays 0, and the block returns to idle so the host can retry once dir has fallen.
- R8: Error injection (`cmd_op`=4) drives 0xFF for max(`cmd_err_cycles`, 2) cycles whatever nxt does, then ends with the stp cycle of R4.
- R9: While `float_en` is 1, `ulpi_data_oe` and `ulpi_stp_oe` are both 0.
- R10: A transmit with `cmd_len`=0 sends stp in the cycle right after the command byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-supplied clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start an operation; taken only when cmd_ready is 1 |
| cmd_op | input | 3 | 1 write, 2 read, 3 transmit, 4 error injection |
| cmd_addr | input | 6 | Register address |
| cmd_wdata | input | 8 | Register write value |
| cmd_pid | input | 4 | Packet identifier for a transmit |
| cmd_len | input | LEN_W | Number of buffer bytes to transmit |
| cmd_err_cycles | input | ERR_CNT_W | Length of the injected 0xFF run |
| cmd_ready | output | 1 | Idle and owning the bus |
| buf_we | input | 1 | Buffer write strobe |
| buf_waddr | input | AW | Buffer write index |
| buf_wdata | input | 8 | Buffer write byte |
| float_en | input | 1 | Release data and stp drivers |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | One-cycle abort pulse |
| rd_data | output | 8 | Byte captured by the last read |
| ulpi_data_i | input | 8 | Data lines as seen from the bus |
| ulpi_data_o | output | 8 | Data value driven by the link |
| ulpi_data_oe | output | 1 | Data output enable |
| ulpi_dir | input | 1 | Bus direction from the PHY |
| ulpi_nxt | input | 1 | PHY throttle/accept strobe |
| ulpi_stp | output | 1 | Stop strobe |
| ulpi_stp_oe | output | 1 | Stop output enable |

## Verification
The assertions assume a PHY that changes dir and nxt only at clock edges, that raises nxt only while the link owns the bus, and that holds dir low through reset. They also assume the host raises `cmd_valid` only when `cmd_ready` is 1. The bench plays the PHY from scripted tasks that set dir, nxt and the read byte just after the falling edge. It raises nxt only for bytes the link is driving, and it brings dir up only in the read reply or in the deliberate abort cases.

// File: rtl/ulpi_lt_pkg.sv
package ulpi_lt_pkg;

   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_REG_WR = 3'd1,
      OP_REG_RD = 3'd2,
      OP_TX     = 3'd3,
      OP_ERR    = 3'd4
   } lt_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CMD,
      S_DATA,
      S_WDATA,
      S_RDWAIT,
      S_ERR,
      S_STP
   } lt_state_e;

   localparam logic [1:0] CT_TX = 2'b01;
   localparam logic [1:0] CT_WR = 2'b10;
   localparam logic [1:0] CT_RD = 2'b11;

   localparam logic [7:0] BYTE_IDLE  = 8'h00;
   localparam logic [7:0] BYTE_FORCE = 8'hFF;

endpackage

// File: rtl/ulpi_lt_txbuf.sv
module ulpi_lt_txbuf #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   parameter bit CLEAR = 1'b1,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem [DEPTH];

   generate
      if (CLEAR) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we && rst_n) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];

endmodule

// File: rtl/ulpi_lt_busif.sv
module ulpi_lt_busif #(
   parameter bit FLOAT_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir,
   input  logic float_en,
   output logic own,
   output logic turn,
   output logic data_oe,
   output logic stp_oe
);

   logic dir_q;
   logic float_g;

   always_ff @(posedge clk) begin
      if (!rst_n) dir_q <= 1'b0;
      else        dir_q <= dir;
   end

   generate
      if (FLOAT_SUPPORT) begin : g_float
         assign float_g = float_en;
      end else begin : g_nofloat
         assign float_g = 1'b0 & float_en;
      end
   endgenerate

   assign turn    = dir ^ dir_q;
   assign own     = !dir && !dir_q;
   assign data_oe = own && !float_g;
   assign stp_oe  = !float_g;

endmodule

// File: rtl/ulpi_lt_seq.sv
module ulpi_lt_seq
   import ulpi_lt_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int ERR_CNT_W = 8,
   localparam int AW       = $clog2(DEPTH),
   localparam int LEN_W    = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [2:0]           cmd_op,
   input  logic [5:0]           cmd_addr,
   input  logic [7:0]           cmd_wdata,
   input  logic [3:0]           cmd_pid,
   input  logic [LEN_W-1:0]     cmd_len,
   input  logic [ERR_CNT_W-1:0] cmd_err_cycles,
   output logic                 cmd_ready,
   input  logic                 dir,
   input  logic                 nxt,
   input  logic                 own,
   input  logic                 turn,
   input  logic [7:0]           data_i,
   input  logic [7:0]           buf_rdata,
   output logic [AW-1:0]        buf_raddr,
   output logic [7:0]           data_o,
   output logic                 stp,
   output logic                 done,
   output logic                 aborted,
   output logic [7:0]           rd_data
);

   lt_state_e            state;
   lt_op_e               kind_q;
   logic [7:0]           cmd_byte_q;
   logic [7:0]           wdata_q;
   logic [LEN_W-1:0]     len_q;
   logic [AW-1:0]        idx;
   logic [ERR_CNT_W-1:0] cnt_q;
   lt_op_e               op_in;
   logic                 start;
   logic                 last_byte;
   logic                 driving;

   assign op_in     = lt_op_e'(cmd_op);
   assign cmd_ready = (state == S_IDLE) && own;
   assign start     = cmd_ready && cmd_valid;
   assign last_byte = (LEN_W'(idx) + LEN_W'(1)) == len_q;
   assign driving   = (state == S_CMD) || (state == S_DATA) ||
                      (state == S_WDATA) || (state == S_ERR);
   assign buf_raddr = idx;
   assign stp       = (state == S_STP);

   always_comb begin
      case (state)
         S_CMD:   data_o = cmd_byte_q;
         S_DATA:  data_o = buf_rdata;
         S_WDATA: data_o = wdata_q;
         S_ERR:   data_o = BYTE_FORCE;
         default: data_o = BYTE_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         kind_q     <= OP_NONE;
         cmd_byte_q <= '0;
         wdata_q    <= '0;
         len_q      <= '0;
         idx        <= '0;
         cnt_q      <= '0;
         done       <= 1'b0;
         aborted    <= 1'b0;
         rd_data    <= '0;
      end else begin
         done    <= 1'b0;
         aborted <= 1'b0;
         if (driving && dir) begin
            aborted <= 1'b1;
            state   <= S_IDLE;
         end else begin
            case (state)
               S_IDLE: begin
                  if (start) begin
                     kind_q <= op_in;
                     idx    <= '0;
                     case (op_in)
                        OP_TX: begin
                           cmd_byte_q <= {CT_TX, 2'b00, cmd_pid};
                           len_q      <= (cmd_len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : cmd_len;
                           state      <= S_CMD;
                        end
                        OP_REG_WR: begin
                           cmd_byte_q <= {CT_WR, cmd_addr};
                           wdata_q    <= cmd_wdata;
                           state      <= S_CMD;
                        end
                        OP_REG_RD: begin
                           cmd_byte_q <= {CT_RD, cmd_addr};
                           state      <= S_CMD;
                        end
                        OP_ERR: begin
                           cnt_q <= (cmd_err_cycles < ERR_CNT_W'(2)) ?
                                    ERR_CNT_W'(1) : cmd_err_cycles - ERR_CNT_W'(1);
                           state <= S_ERR;
                        end
                        default: state <= S_IDLE;
                     endcase
                  end
               end
               S_CMD: begin
                  if (nxt && own) begin
                     case (kind_q)
                        OP_TX:     state <= (len_q == '0) ? S_STP : S_DATA;
                        OP_REG_WR: state <= S_WDATA;
                        default:   state <= S_RDWAIT;
                     endcase
                  end
               end
               S_DATA: begin
                  if (nxt && own) begin
                     if (last_byte) state <= S_STP;
                     else           idx   <= idx + AW'(1);
                  end
               end
               S_WDATA: begin
                  if (nxt && own) state <= S_STP;
               end
               S_ERR: begin
                  if (cnt_q == '0) state <= S_STP;
                  else             cnt_q <= cnt_q - ERR_CNT_W'(1);
               end
               S_RDWAIT: begin
                  if (dir && !turn) begin
                     rd_data <= data_i;
                     done    <= 1'b1;
                     state   <= S_IDLE;
                  end
               end
               S_STP: begin
                  done  <= 1'b1;
                  state <= S_IDLE;
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/ulpi_link_tester.sv
module ulpi_link_tester
   import ulpi_lt_pkg::*;
#(
   parameter int BUF_DEPTH     = 16,
   parameter int DATA_W        = 8,
   parameter int ERR_CNT_W     = 8,
   parameter bit CLEAR_BUF     = 1'b1,
   parameter bit FLOAT_SUPPORT = 1'b1,
   localparam int AW           = $clog2(BUF_DEPTH),
   localparam int LEN_W        = $clog2(BUF_DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [2:0]           cmd_op,
   input  logic [5:0]           cmd_addr,
   input  logic [7:0]           cmd_wdata,
   input  logic [3:0]           cmd_pid,
   input  logic [LEN_W-1:0]     cmd_len,
   input  logic [ERR_CNT_W-1:0] cmd_err_cycles,
   output logic                 cmd_ready,
   input  logic                 buf_we,
   input  logic [AW-1:0]        buf_waddr,
   input  logic [7:0]           buf_wdata,
   input  logic                 float_en,
   output logic                 done,
   output logic                 aborted,
   output logic [7:0]           rd_data,
   input  logic [7:0]           ulpi_data_i,
   output logic [7:0]           ulpi_data_o,
   output logic                 ulpi_data_oe,
   input  logic                 ulpi_dir,
   input  logic                 ulpi_nxt,
   output logic                 ulpi_stp,
   output logic                 ulpi_stp_oe
);

   if (DATA_W != 8) begin : g_chk_w
      $error("ulpi_link_tester: the bus is eight bits wide");
   end
   if (BUF_DEPTH < 2 || (1 << AW) != BUF_DEPTH) begin : g_chk_d
      $error("ulpi_link_tester: BUF_DEPTH must be a power of two, at least 2");
   end
   if (ERR_CNT_W < 2) begin : g_chk_e
      $error("ulpi_link_tester: ERR_CNT_W must be at least 2");
   end

   logic          own;
   logic          turn;
   logic [AW-1:0] buf_raddr;
   logic [7:0]    buf_rdata;

   ulpi_lt_busif #(.FLOAT_SUPPORT(FLOAT_SUPPORT)) u_busif (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir      (ulpi_dir),
      .float_en (float_en),
      .own      (own),
      .turn     (turn),
      .data_oe  (ulpi_data_oe),
      .stp_oe   (ulpi_stp_oe)
   );

   ulpi_lt_txbuf #(.DEPTH(BUF_DEPTH), .W(DATA_W), .CLEAR(CLEAR_BUF)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (buf_we),
      .waddr (buf_waddr),
      .wdata (buf_wdata),
      .raddr (buf_raddr),
      .rdata (buf_rdata)
   );

   ulpi_lt_seq #(.DEPTH(BUF_DEPTH), .ERR_CNT_W(ERR_CNT_W)) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_valid      (cmd_valid),
      .cmd_op         (cmd_op),
      .cmd_addr       (cmd_addr),
      .cmd_wdata      (cmd_wdata),
      .cmd_pid        (cmd_pid),
      .cmd_len        (cmd_len),
      .cmd_err_cycles (cmd_err_cycles),
      .cmd_ready      (cmd_ready),
      .dir            (ulpi_dir),
      .nxt            (ulpi_nxt),
      .own            (own),
      .turn           (turn),
      .data_i         (ulpi_data_i),
      .buf_rdata      (buf_rdata),
      .buf_raddr      (buf_raddr),
      .data_o         (ulpi_data_o),
      .stp            (ulpi_stp),
      .done           (done),
      .aborted        (aborted),
      .rd_data        (rd_data)
   );

endmodule

// File: rtl/ulpi_lt_checker.sv
module ulpi_lt_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       dir,
   input logic       nxt,
   input logic       float_en,
   input logic       data_oe,
   input logic       stp_oe,
   input logic       stp,
   input logic [7:0] data_o,
   input logic       done,
   input logic       aborted,
   input logic       cmd_ready
);

   p_no_drive_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dir |-> !data_oe);

   p_turnaround_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dir != $past(dir)) |-> !data_oe);

   p_hold_until_nxt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe && !nxt && !stp && data_o != 8'h00 && data_o != 8'hFF)
      |=> (dir || data_o == $past(data_o)));

   p_stp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stp |=> !stp);

   p_done_after_stp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stp |=> done);

   p_abort_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      aborted |-> !done && !stp);

   p_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
      float_en |-> (!data_oe && !stp_oe));

   p_ready_owns_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (data_oe || float_en));

endmodule

bind ulpi_link_tester ulpi_lt_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dir       (ulpi_dir),
   .nxt       (ulpi_nxt),
   .float_en  (float_en),
   .data_oe   (ulpi_data_oe),
   .stp_oe    (ulpi_stp_oe),
   .stp       (ulpi_stp),
   .data_o    (ulpi_data_o),
   .done      (done),
   .aborted   (aborted),
   .cmd_ready (cmd_ready)
);

// File: tb/ulpi_link_tester_bench.sv
module ulpi_link_tester_bench;

   localparam int DEPTH = 16;
   localparam int AW    = 4;
   localparam int LW    = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [5:0] cmd_addr = '0;
   logic [7:0] cmd_wdata = '0;
   logic [3:0] cmd_pid = '0;
   logic [LW-1:0] cmd_len = '0;
   logic [7:0] cmd_err_cycles = '0;
   logic cmd_ready;
   logic buf_we = 1'b0;
   logic [AW-1:0] buf_waddr = '0;
   logic [7:0] buf_wdata = '0;
   logic float_en = 1'b0;
   logic done, aborted;
   logic [7:0] rd_data;
   logic [7:0] ulpi_data_i = '0;
   logic [7:0] ulpi_data_o;
   logic ulpi_data_oe;
   logic ulpi_dir = 1'b0;
   logic ulpi_nxt = 1'b0;
   logic ulpi_stp, ulpi_stp_oe;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   logic [7:0] bufv [DEPTH];

   always #5 clk = ~clk;

   ulpi_link_tester u_ulpi_link_tester (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_pid(cmd_pid),
      .cmd_len(cmd_len), .cmd_err_cycles(cmd_err_cycles), .cmd_ready(cmd_ready),
      .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
      .float_en(float_en), .done(done), .aborted(aborted), .rd_data(rd_data),
      .ulpi_data_i(ulpi_data_i), .ulpi_data_o(ulpi_data_o),
      .ulpi_data_oe(ulpi_data_oe), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
      .ulpi_stp(ulpi_stp), .ulpi_stp_oe(ulpi_stp_oe)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic nx();
      @(negedge clk);
   endtask

   function automatic logic pat_bit(input int c, input int pat);
      if (pat == 0) return 1'b1;
      if (pat == 3) return c[0];
      return ((c + pat) % 3) != 0;
   endfunction

   task automatic load_buf(input int len);
      for (int i = 0; i < len; i++) begin
         nx(); buf_we = 1'b1; buf_waddr = AW'(i); buf_wdata = bufv[i];
      end
      nx(); buf_we = 1'b0;
   endtask

   task automatic issue(input logic [2:0] op);
      nx(); #1;
      chk(cmd_ready, "R1 ready before command", cmd_ready, 1);
      cmd_valid = 1'b1; cmd_op = op;
      nx(); cmd_valid = 1'b0;
   endtask

   task automatic finish_stp(input string req);
      ulpi_nxt = 1'b0; #1;
      chk(ulpi_stp && ulpi_data_o == 8'h00, req, {ulpi_stp, ulpi_data_o}, 9'h100);
      nx(); #1;
      chk(!ulpi_stp && done, "R4 done after single stp", {ulpi_stp, done}, 1);
   endtask

   task automatic run_tx(input int len, input logic [3:0] pid, input int pat);
      int k = 0;
      int c = 0;
      logic [7:0] e;
      load_buf(len);
      cmd_pid = pid; cmd_len = LW'(len);
      issue(3'd3);
      while (k <= len && c < 200) begin
         ulpi_nxt = pat_bit(c, pat); #1;
         e = (k == 0) ? {2'b01, 2'b00, pid} : bufv[k-1];
         chk(ulpi_data_o == e && ulpi_data_oe && !ulpi_stp, "R3 transmit byte", ulpi_data_o, e);
         if (ulpi_nxt) k++;
         c++;
         nx();
      end
      finish_stp(len == 0 ? "R10 stp after bare command" : "R4 stp after last byte");
   endtask

   task automatic run_wr(input logic [5:0] a, input logic [7:0] d, input int pat);
      int k = 0;
      int c = 0;
      logic [7:0] e;
      cmd_addr = a; cmd_wdata = d;
      issue(3'd1);
      while (k < 2 && c < 50) begin
         ulpi_nxt = pat_bit(c, pat); #1;
         e = (k == 0) ? {2'b10, a} : d;
         chk(ulpi_data_o == e, "R5 write byte", ulpi_data_o, e);
         if (ulpi_nxt) k++;
         c++;
         nx();
      end
      finish_stp("R5 stp after write data");
   endtask

   task automatic run_rd(input logic [5:0] a);
      logic [7:0] e;
      e = (a == 6'h04) ? 8'h45 : 8'((a * 3) + 1);
      cmd_addr = a;
      issue(3'd2);
      ulpi_nxt = 1'b0; #1;
      chk(ulpi_data_o == {2'b11, a}, "R6 read command byte", ulpi_data_o, {2'b11, a});
      nx(); ulpi_nxt = 1'b1; #1;
      chk(ulpi_data_o == {2'b11, a}, "R6 read command held", ulpi_data_o, {2'b11, a});
      nx(); ulpi_nxt = 1'b0; ulpi_dir = 1'b1; ulpi_data_i = 8'hA5; #1;
      chk(!ulpi_data_oe, "R2 no drive on dir rise", ulpi_data_oe, 0);
      nx(); ulpi_data_i = e; #1;
      chk(!ulpi_data_oe && !done, "R2 phy owns bus", {ulpi_data_oe, done}, 0);
      nx(); ulpi_dir = 1'b0; ulpi_data_i = 8'h00; #1;
      chk(done && rd_data == e, "R6 read data", rd_data, e);
      chk(!ulpi_data_oe, "R2 turnaround after dir fall", ulpi_data_oe, 0);
      nx(); #1;
      chk(ulpi_data_oe && cmd_ready, "R2 bus regained", {ulpi_data_oe, cmd_ready}, 3);
   endtask

   task automatic run_err(input int n);
      int expc;
      expc = (n < 2) ? 2 : n;
      cmd_err_cycles = 8'(n);
      issue(3'd4);
      for (int i = 0; i < expc; i++) begin
         ulpi_nxt = i[0]; #1;
         chk(ulpi_data_o == 8'hFF && !ulpi_stp, "R8 forced ones", ulpi_data_o, 8'hFF);
         nx();
      end
      finish_stp("R8 stp ends forced run");
   endtask

   task automatic abort_tail();
      nx(); #1;
      chk(aborted && !done && !ulpi_stp, "R7 abort reported", {aborted, done, ulpi_stp}, 4);
      nx(); ulpi_dir = 1'b0; #1;
      chk(!ulpi_data_oe && !aborted, "R2 turnaround after abort", {ulpi_data_oe, aborted}, 0);
      nx(); #1;
      chk(cmd_ready && ulpi_data_o == 8'h00 && !done, "R7 idle after abort",
          {cmd_ready, ulpi_data_o}, 9'h100);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) bufv[i] = '0;
      repeat (3) nx();
      rst_n = 1'b1;
      nx(); #1;
      chk(cmd_ready && ulpi_data_oe && ulpi_stp_oe && ulpi_data_o == 8'h00,
          "R1 reset state", {cmd_ready, ulpi_data_oe, ulpi_stp_oe, ulpi_data_o}, 11'h700);
      chk(!ulpi_stp && !done && !aborted, "R1 reset strobes", {ulpi_stp, done, aborted}, 0);

      bufv[0] = 8'hDD; bufv[1] = 8'h0D; bufv[2] = 8'h6F;
      bufv[3] = 8'h64; bufv[4] = 8'h10; bufv[5] = 8'h7A;
      run_tx(6, 4'h3, 0);
      run_tx(6, 4'hB, 1);

      for (int len = 0; len <= 5; len++) begin
         for (int pat = 0; pat < 4; pat++) begin
            for (int i = 0; i < DEPTH; i++) bufv[i] = 8'((i * 37) + (pat * 11) + len + 7);
            run_tx(len, 4'(len + pat), pat);
         end
      end
      for (int i = 0; i < DEPTH; i++) bufv[i] = 8'(255 - i * 5);
      run_tx(DEPTH, 4'h1, 2);

      run_wr(6'h00, 8'h5A, 0);
      run_wr(6'h04, 8'h45, 1);
      run_wr(6'h15, 8'hC3, 3);
      run_wr(6'h3F, 8'h01, 2);

      for (int a = 0; a < 8; a++) run_rd(6'(a));
      run_rd(6'h3F);

      run_err(0);
      run_err(1);
      run_err(2);
      run_err(3);
      run_err(7);

      // R7 abort on the command byte
      bufv[0] = 8'h11; bufv[1] = 8'h22;
      load_buf(2);
      cmd_pid = 4'h5; cmd_len = LW'(2);
      issue(3'd3);
      ulpi_nxt = 1'b0; ulpi_dir = 1'b1; #1;
      chk(!ulpi_data_oe, "R2 no drive while dir high", ulpi_data_oe, 0);
      abort_tail();

      // R7 abort on the write data byte
      cmd_addr = 6'h0A; cmd_wdata = 8'h77;
      issue(3'd1);
      ulpi_nxt = 1'b1; #1;
      nx(); ulpi_nxt = 1'b0; ulpi_dir = 1'b1; #1;
      chk(!ulpi_stp, "R7 no stp on abort", ulpi_stp, 0);
      abort_tail();

      // R7 abort during forced ones
      cmd_err_cycles = 8'd6;
      issue(3'd4);
      ulpi_dir = 1'b1;
      abort_tail();

      // R9 float mode
      nx(); float_en = 1'b1; #1;
      chk(!ulpi_data_oe && !ulpi_stp_oe, "R9 float releases both", {ulpi_data_oe, ulpi_stp_oe}, 0);
      nx(); #1;
      chk(!ulpi_data_oe && !ulpi_stp_oe, "R9 float held", {ulpi_data_oe, ulpi_stp_oe}, 0);
      nx(); float_en = 1'b0; #1;
      chk(ulpi_data_oe && ulpi_stp_oe, "R9 float released", {ulpi_data_oe, ulpi_stp_oe}, 3);

      run_rd(6'h04);

      nx();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule